// File: doc/BRIEF.md
# Power-Up Configuration Sequencer

This block walks a programmable device from the moment its supply is declared good up to the point where configuration data may be loaded. It then tracks the load until the device is running. After power-good it keeps the user output drivers off with pull-ups on. It waits out an initialization delay counted in ticks of an internal timer, and that delay is four times longer when the strap pins select a master mode. It then runs a memory-clear phase. Before any load is allowed it waits for an external active-low reset to be released and takes a final sample of the three mode straps.

During a load, an external reset held low for a set number of timer ticks aborts it. The controller then goes back through clear and samples the straps again. When the device is running, a falling edge on the reprogram pin starts the same clear-and-resample path. An active-low initialization flag and a complementary pair of status pins (one driven high, one driven low while the device is not yet running) let board logic follow the sequence. The load itself is represented by a completion input, and power detection is represented by a power-good input.

Top module: `cfg_boot_seq`

## Requirements
- R1: While `pwr_good` is low, and right after it rises, the outputs are: `init_n`=0, `hdc`=1, `ldc`=0, `io_enable`=0, `pullup_en`=1, `clr_mem`=0 and `load_en`=0.
- R2: When the straps `mode_pins` at power-up are not a master code, the initialization phase lasts 2^CNT_W timer ticks. With a tick every TICK_DIV clocks, `clr_mem` first goes high on clock edge number TICK_DIV*2^CNT_W after `pwr_good` rises.
- R3: When the straps at power-up are a master code (000, 001 or 011), the initialization phase lasts 2^(CNT_W+2) timer ticks.
- R4: The clear phase holds `clr_mem` high for exactly CLEAR_TICKS ticks. `init_n` is low through initialization and clear, and high once clear ends.
- R5: After clear, the controller waits while the synchronized `ext_reset_n` is low (`load_en`=0, `init_n`=1, `hdc`=1). Once reset is high it samples `mode_pins` and, if the code is valid, raises `load_en`.
- R6: `mode_pins[2:0]` is read as {m2,m1,m0}, and the latched code appears on `cfg_mode`. The decode is: 000 is master serial (`mode_master`=1); 001 is master byte-wide counting up (`mode_master`=1, `mode_byte`=1); 011 is master byte-wide counting down (`mode_master`=1, `mode_byte`=1, `mode_down`=1); 101 is peripheral byte-wide (`mode_byte`=1); 111 is slave serial (all three flags 0).
- R7: A reserved code (010, 100, 110) sampled in the wait state sets `mode_err` and keeps `load_en` low. The controller keeps sampling, and a later valid code clears `mode_err` and starts the load.
- R8: During a load, `ext_reset_n` low across ABORT_TICKS timer ticks drops `load_en` and reenters clear, after which R5 applies again. A low pulse that spans fewer ticks has no effect.
- R9: `load_done` high during a load puts the controller in the running state on the next clock: `io_enable`=1, `pullup_en`=0, `hdc`=0, `ldc`=1, `init_n`=1.
- R10: In the running state a falling edge on `prog_n` (seen through its synchronizer) reenters clear and then resamples the straps. A falling edge during a load is ignored.
- R11: `hdc` is high and `ldc` low in every state except running, where both are inverted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that also derives the timer tick |
| pwr_good | input | 1 | Supply good; low resets the whole sequence asynchronously |
| ext_reset_n | input | 1 | External active-low reset, asynchronous |
| mode_pins | input | 3 | Mode straps {m2,m1,m0} |
| load_done | input | 1 | Configuration memory full and count matched |
| prog_n | input | 1 | Reprogram pin level; a falling edge requests reprogram |
| init_n | output | 1 | Low during initialization and clear |
| hdc | output | 1 | High until running |
| ldc | output | 1 | Low until running |
| clr_mem | output | 1 | Configuration memory clear strobe |
| load_en | output | 1 | Configuration load window open |
| io_enable | output | 1 | User output buffers enabled |
| pullup_en | output | 1 | Pull-ups on user pins enabled |
| cfg_mode | output | 3 | Latched mode code |
| mode_master | output | 1 | Latched code is a master mode |
| mode_byte | output | 1 | Latched code is byte-wide |
| mode_down | output | 1 | Byte-wide address counts down |
| mode_err | output | 1 | Reserved code seen in wait state |

## Verification
The assertions assume that the mode straps are static at power-up and at the wait-state sample, so a latched code always matches the straps of the cycle it was taken in. They also assume that `pwr_good` is the only reset. The stimulus changes the straps only while the controller is clearing, running or deliberately waiting on a reserved code. It raises `load_done` only when `load_en` is high, and it drives every input on the falling clock edge. Reset pulses for the abort cases are sized in whole clocks, so the number of ticks they span is bounded on both sides.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

   typedef enum logic [2:0] {
      ST_INIT  = 3'd0,
      ST_CLEAR = 3'd1,
      ST_WAIT  = 3'd2,
      ST_LOAD  = 3'd3,
      ST_RUN   = 3'd4
   } seq_state_e;

   typedef struct packed {
      logic valid;
      logic master;
      logic byte_wide;
      logic addr_down;
   } mode_info_t;

   // code is {m2,m1,m0}
   function automatic mode_info_t decode_mode(input logic [2:0] code);
      mode_info_t r;
      r = '0;
      case (code)
         3'b000: begin r.valid = 1'b1; r.master = 1'b1; end
         3'b001: begin r.valid = 1'b1; r.master = 1'b1; r.byte_wide = 1'b1; end
         3'b011: begin r.valid = 1'b1; r.master = 1'b1; r.byte_wide = 1'b1; r.addr_down = 1'b1; end
         3'b101: begin r.valid = 1'b1; r.byte_wide = 1'b1; end
         3'b111: begin r.valid = 1'b1; end
         default: r = '0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/cfgseq_sync.sv
module cfgseq_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic arst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   initial begin
      assert (STAGES >= 1) else $error("cfgseq_sync: STAGES must be at least 1");
   end

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) chain <= RST_VAL;
            else         chain <= d;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) chain <= {STAGES{RST_VAL}};
            else         chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/cfgseq_tick.sv
module cfgseq_tick #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic arst_n,
   output logic tick
);
   initial begin
      assert (DIV >= 1) else $error("cfgseq_tick: DIV must be at least 1");
   end

   generate
      if (DIV == 1) begin : g_every
         assign tick = 1'b1;
      end else begin : g_div
         localparam int DW = $clog2(DIV);
         localparam logic [DW-1:0] LAST = DW'(DIV - 1);
         logic [DW-1:0] cnt;

         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n)          cnt <= '0;
            else if (cnt == LAST) cnt <= '0;
            else                  cnt <= cnt + 1'b1;
         end

         assign tick = (cnt == LAST);

         assert_tick_in_range_R2: assert property (@(posedge clk) disable iff (!arst_n)
            (cnt <= LAST));
         assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!arst_n)
            tick |=> !tick);
      end
   endgenerate
endmodule

// File: rtl/cfgseq_tcnt.sv
module cfgseq_tcnt #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         arst_n,
   input  logic         clr,
   input  logic         en,
   output logic [W-1:0] cnt
);
   initial begin
      assert (W >= 1) else $error("cfgseq_tcnt: W must be at least 1");
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)  cnt <= '0;
      else if (clr) cnt <= '0;
      else if (en)  cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/cfg_boot_seq.sv
module cfg_boot_seq
   import cfgseq_pkg::*;
#(
   parameter int CNT_W        = 14,
   parameter int MASTER_SHIFT = 2,
   parameter int TICK_DIV     = 4,
   parameter int CLEAR_TICKS  = 4,
   parameter int ABORT_TICKS  = 3,
   parameter int SYNC_STAGES  = 2
) (
   input  logic       clk,
   input  logic       pwr_good,
   input  logic       ext_reset_n,
   input  logic [2:0] mode_pins,
   input  logic       load_done,
   input  logic       prog_n,
   output logic       init_n,
   output logic       hdc,
   output logic       ldc,
   output logic       clr_mem,
   output logic       load_en,
   output logic       io_enable,
   output logic       pullup_en,
   output logic [2:0] cfg_mode,
   output logic       mode_master,
   output logic       mode_byte,
   output logic       mode_down,
   output logic       mode_err
);
   localparam int IW = CNT_W + MASTER_SHIFT;
   localparam int CW = $clog2(CLEAR_TICKS + 1);
   localparam int AW = $clog2(ABORT_TICKS + 1);
   localparam logic [IW-1:0] SHORT_LAST = IW'((1 << CNT_W) - 1);
   localparam logic [CW-1:0] CLEAR_LAST = CW'(CLEAR_TICKS - 1);
   localparam logic [AW-1:0] ABORT_LAST = AW'(ABORT_TICKS - 1);

   initial begin
      assert (CNT_W >= 2)        else $error("cfg_boot_seq: CNT_W too small");
      assert (MASTER_SHIFT >= 0) else $error("cfg_boot_seq: MASTER_SHIFT negative");
      assert (CLEAR_TICKS >= 1)  else $error("cfg_boot_seq: CLEAR_TICKS must be positive");
      assert (ABORT_TICKS >= 1)  else $error("cfg_boot_seq: ABORT_TICKS must be positive");
      assert (SYNC_STAGES >= 2)  else $error("cfg_boot_seq: need two or more sync stages");
   end

   seq_state_e st, nx;
   logic       tick, rst_s, prog_s, prog_d, prog_fall;
   logic       started, master_q, err_q;
   logic [2:0] mode_q;
   logic [IW-1:0] init_cnt;
   logic [CW-1:0] clr_cnt;
   logic [AW-1:0] abt_cnt;
   logic       init_last, clr_last, abort_hit, mode_ok;
   mode_info_t info_live, info_q;

   // ---------------- timer and input conditioning ----------------
   cfgseq_tick #(.DIV(TICK_DIV)) u_tick (
      .clk(clk), .arst_n(pwr_good), .tick(tick));

   cfgseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rst_sync (
      .clk(clk), .arst_n(pwr_good), .d(ext_reset_n), .q(rst_s));

   cfgseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_prog_sync (
      .clk(clk), .arst_n(pwr_good), .d(prog_n), .q(prog_s));

   always_ff @(posedge clk or negedge pwr_good) begin
      if (!pwr_good) prog_d <= 1'b1;
      else           prog_d <= prog_s;
   end
   assign prog_fall = prog_d & ~prog_s;

   assign info_live = decode_mode(mode_pins);
   assign info_q    = decode_mode(mode_q);
   assign mode_ok   = info_live.valid;

   // ---------------- phase counters ----------------
   cfgseq_tcnt #(.W(IW)) u_init_cnt (
      .clk(clk), .arst_n(pwr_good), .clr(st != ST_INIT), .en(tick), .cnt(init_cnt));

   cfgseq_tcnt #(.W(CW)) u_clr_cnt (
      .clk(clk), .arst_n(pwr_good), .clr(st != ST_CLEAR), .en(tick), .cnt(clr_cnt));

   cfgseq_tcnt #(.W(AW)) u_abt_cnt (
      .clk(clk), .arst_n(pwr_good), .clr((st != ST_LOAD) || rst_s), .en(tick), .cnt(abt_cnt));

   generate
      if (MASTER_SHIFT == 0) begin : g_no_ext
         assign init_last = tick && (init_cnt == SHORT_LAST);
      end else begin : g_ext
         assign init_last = tick && (master_q ? (&init_cnt) : (&init_cnt[CNT_W-1:0]));
      end
   endgenerate

   assign clr_last  = tick && (clr_cnt == CLEAR_LAST);
   assign abort_hit = tick && !rst_s && (abt_cnt == ABORT_LAST);

   // ---------------- sequencer ----------------
   always_comb begin
      nx = st;
      case (st)
         ST_INIT:  if (init_last) nx = ST_CLEAR;
         ST_CLEAR: if (clr_last)  nx = ST_WAIT;
         ST_WAIT:  if (rst_s && mode_ok) nx = ST_LOAD;
         ST_LOAD: begin
            if (abort_hit)      nx = ST_CLEAR;
            else if (load_done) nx = ST_RUN;
         end
         ST_RUN:   if (prog_fall) nx = ST_CLEAR;
         default:  nx = ST_INIT;
      endcase
   end

   always_ff @(posedge clk or negedge pwr_good) begin
      if (!pwr_good) begin
         st       <= ST_INIT;
         started  <= 1'b0;
         master_q <= 1'b0;
         mode_q   <= 3'b000;
         err_q    <= 1'b0;
      end else begin
         st      <= nx;
         started <= 1'b1;
         if (!started) master_q <= info_live.master;
         if (st == ST_WAIT && nx == ST_LOAD) mode_q <= mode_pins;
         err_q <= (st == ST_WAIT) && (rst_s ? !mode_ok : err_q);
      end
   end

   // ---------------- outputs ----------------
   assign init_n      = !((st == ST_INIT) || (st == ST_CLEAR));
   assign clr_mem     = (st == ST_CLEAR);
   assign load_en     = (st == ST_LOAD);
   assign io_enable   = (st == ST_RUN);
   assign pullup_en   = (st != ST_RUN);
   assign hdc         = (st != ST_RUN);
   assign ldc         = (st == ST_RUN);
   assign cfg_mode    = mode_q;
   assign mode_master = info_q.master;
   assign mode_byte   = info_q.byte_wide;
   assign mode_down   = info_q.addr_down;
   assign mode_err    = err_q;

   // ---------------- assertions ----------------
   assert_short_init_bound_R3: assert property (@(posedge clk) disable iff (!pwr_good)
      (st == ST_INIT && !master_q) |-> (init_cnt <= SHORT_LAST));

   assert_clear_exits_to_wait_R4: assert property (@(posedge clk) disable iff (!pwr_good)
      (st == ST_CLEAR) |=> (st == ST_CLEAR || st == ST_WAIT));

   assert_load_needs_reset_high_R5: assert property (@(posedge clk) disable iff (!pwr_good)
      $rose(load_en) |-> ($past(rst_s) && $past(mode_ok)));

   assert_latched_code_valid_R6: assert property (@(posedge clk) disable iff (!pwr_good)
      load_en |-> info_q.valid);

   assert_err_only_waiting_R7: assert property (@(posedge clk) disable iff (!pwr_good)
      mode_err |-> (st == ST_WAIT));

   assert_abort_count_bound_R8: assert property (@(posedge clk) disable iff (!pwr_good)
      (st == ST_LOAD) |-> (abt_cnt <= ABORT_LAST));

   assert_run_after_done_R9: assert property (@(posedge clk) disable iff (!pwr_good)
      $rose(io_enable) |-> $past(load_done));

   assert_run_exit_clears_R10: assert property (@(posedge clk) disable iff (!pwr_good)
      $fell(io_enable) |-> clr_mem);

   assert_status_pair_R11: assert property (@(posedge clk) disable iff (!pwr_good)
      io_enable |-> (!hdc && ldc && init_n && !pullup_en));
endmodule

// File: tb/cfg_boot_seq_bench.sv
`timescale 1ns/1ps
module cfg_boot_seq_bench;
   localparam int CNT_W       = 4;
   localparam int TICK_DIV    = 2;
   localparam int CLEAR_TICKS = 3;
   localparam int ABORT_TICKS = 3;

   logic       clk = 1'b0;
   logic       pwr_good = 1'b0;
   logic       ext_reset_n = 1'b1;
   logic [2:0] mode_pins = 3'b111;
   logic       load_done = 1'b0;
   logic       prog_n = 1'b1;
   logic       init_n, hdc, ldc, clr_mem, load_en, io_enable, pullup_en;
   logic [2:0] cfg_mode;
   logic       mode_master, mode_byte, mode_down, mode_err;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   cfg_boot_seq #(
      .CNT_W(CNT_W), .MASTER_SHIFT(2), .TICK_DIV(TICK_DIV),
      .CLEAR_TICKS(CLEAR_TICKS), .ABORT_TICKS(ABORT_TICKS), .SYNC_STAGES(2)
   ) u_cfg_boot_seq (
      .clk(clk), .pwr_good(pwr_good), .ext_reset_n(ext_reset_n), .mode_pins(mode_pins),
      .load_done(load_done), .prog_n(prog_n), .init_n(init_n), .hdc(hdc), .ldc(ldc),
      .clr_mem(clr_mem), .load_en(load_en), .io_enable(io_enable), .pullup_en(pullup_en),
      .cfg_mode(cfg_mode), .mode_master(mode_master), .mode_byte(mode_byte),
      .mode_down(mode_down), .mode_err(mode_err));

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // sel: 0 = load_en high, 1 = clr_mem high, 2 = clr_mem low
   task automatic wait_for(input int sel, input int limit, output bit ok);
      ok = 1'b0;
      for (int i = 0; i < limit; i++) begin
         @(negedge clk);
         if ((sel == 0 && load_en) || (sel == 1 && clr_mem) || (sel == 2 && !clr_mem)) begin
            ok = 1'b1;
            break;
         end
      end
   endtask

   task automatic chk_mode(input logic [2:0] m, input string tag);
      int exp_master, exp_byte, exp_down;
      exp_master = (m == 3'b000 || m == 3'b001 || m == 3'b011) ? 1 : 0;
      exp_byte   = (m == 3'b001 || m == 3'b011 || m == 3'b101) ? 1 : 0;
      exp_down   = (m == 3'b011) ? 1 : 0;
      chk({tag, " cfg_mode"}, int'(cfg_mode), int'(m));
      chk({tag, " master"}, int'(mode_master), exp_master);
      chk({tag, " byte"}, int'(mode_byte), exp_byte);
      chk({tag, " down"}, int'(mode_down), exp_down);
   endtask

   task automatic t_power_up(input logic [2:0] m, input bit hold_rst, input int exp_edges,
                             input string tag);
      int n, c;
      pwr_good = 1'b0; mode_pins = m; ext_reset_n = !hold_rst; load_done = 1'b0; prog_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 init_n off", int'(init_n), 0);
      chk("R1 hdc off", int'(hdc), 1);
      chk("R1 ldc off", int'(ldc), 0);
      chk("R1 io_enable off", int'(io_enable), 0);
      chk("R1 pullup off", int'(pullup_en), 1);
      chk("R1 clr_mem off", int'(clr_mem), 0);
      chk("R1 load_en off", int'(load_en), 0);
      pwr_good = 1'b1;
      n = 0;
      while (n < 5000) begin
         @(posedge clk);
         n++;
         @(negedge clk);
         if (n == 1) begin
            chk("R1 init_n after power good", int'(init_n), 0);
            chk("R11 hdc during init", int'(hdc), 1);
         end
         if (clr_mem) break;
      end
      chk({tag, " init length in clocks"}, n, exp_edges);
      chk("R4 init_n low in clear", int'(init_n), 0);
      c = 0;
      while (clr_mem && c < 1000) begin
         c++;
         @(negedge clk);
      end
      chk("R4 clear length in clocks", c, CLEAR_TICKS * TICK_DIV);
      chk("R4 init_n high after clear", int'(init_n), 1);
   endtask

   task automatic t_go_run();
      load_done = 1'b1;
      @(negedge clk);
      load_done = 1'b0;
      chk("R9 io_enable", int'(io_enable), 1);
      chk("R9 pullup_en", int'(pullup_en), 0);
      chk("R9 init_n", int'(init_n), 1);
      chk("R11 hdc running", int'(hdc), 0);
      chk("R11 ldc running", int'(ldc), 1);
   endtask

   task automatic t_reprog(input logic [2:0] m);
      bit ok;
      mode_pins = m;
      prog_n = 1'b0;
      wait_for(1, 20, ok);
      chk("R10 reprogram enters clear", int'(ok), 1);
      chk("R10 io_enable dropped", int'(io_enable), 0);
      prog_n = 1'b1;
      wait_for(0, 60, ok);
      chk("R10 reload after reprogram", int'(ok), 1);
      chk_mode(m, "R6");
   endtask

   task automatic t_prog_ignored();
      bit saw = 1'b0;
      prog_n = 1'b0;
      for (int i = 0; i < 8; i++) begin @(negedge clk); saw |= clr_mem; end
      prog_n = 1'b1;
      for (int i = 0; i < 6; i++) begin @(negedge clk); saw |= clr_mem; end
      chk("R10 prog edge in load ignored", int'(saw), 0);
      chk("R10 load_en kept", int'(load_en), 1);
   endtask

   task automatic t_short_abort();
      bit saw = 1'b0;
      ext_reset_n = 1'b0;
      repeat (4) @(negedge clk);
      ext_reset_n = 1'b1;
      for (int i = 0; i < 12; i++) begin @(negedge clk); saw |= clr_mem; end
      chk("R8 short reset ignored", int'(saw), 0);
      chk("R8 load_en kept", int'(load_en), 1);
   endtask

   task automatic t_long_abort();
      bit ok, saw;
      mode_pins = 3'b101;
      ext_reset_n = 1'b0;
      wait_for(1, 30, ok);
      chk("R8 long reset aborts", int'(ok), 1);
      chk("R8 load_en dropped", int'(load_en), 0);
      wait_for(2, 30, ok);
      saw = 1'b0;
      for (int i = 0; i < 8; i++) begin @(negedge clk); saw |= load_en; end
      chk("R5 hold while reset low", int'(saw), 0);
      chk("R5 init_n high while waiting", int'(init_n), 1);
      ext_reset_n = 1'b1;
      wait_for(0, 20, ok);
      chk("R8 reload after abort", int'(ok), 1);
      chk_mode(3'b101, "R8 resampled");
   endtask

   task automatic t_reserved();
      bit ok;
      mode_pins = 3'b010;
      prog_n = 1'b0;
      wait_for(1, 20, ok);
      prog_n = 1'b1;
      wait_for(2, 30, ok);
      repeat (3) @(negedge clk);
      chk("R7 err on 010", int'(mode_err), 1);
      chk("R7 no load on 010", int'(load_en), 0);
      chk("R11 hdc waiting", int'(hdc), 1);
      mode_pins = 3'b100;
      repeat (3) @(negedge clk);
      chk("R7 err on 100", int'(mode_err), 1);
      mode_pins = 3'b110;
      repeat (3) @(negedge clk);
      chk("R7 err on 110", int'(mode_err), 1);
      chk("R7 no load on 110", int'(load_en), 0);
      mode_pins = 3'b011;
      wait_for(0, 10, ok);
      chk("R7 valid code recovers", int'(ok), 1);
      chk("R7 err cleared", int'(mode_err), 0);
      chk_mode(3'b011, "R6 after reserved");
   endtask

   initial begin : main
      bit ok, saw;
      t_power_up(3'b111, 1'b1, TICK_DIV * (1 << CNT_W), "R2");
      saw = 1'b0;
      for (int i = 0; i < 8; i++) begin @(negedge clk); saw |= load_en; end
      chk("R5 wait while reset low", int'(saw), 0);
      chk("R5 hdc while waiting", int'(hdc), 1);
      ext_reset_n = 1'b1;
      wait_for(0, 10, ok);
      chk("R5 load after reset release", int'(ok), 1);
      chk_mode(3'b111, "R6 slave");
      t_go_run();
      t_reprog(3'b001);
      t_go_run();
      t_reprog(3'b011);
      t_go_run();
      t_reprog(3'b101);
      t_go_run();
      t_reprog(3'b000);
      t_prog_ignored();
      t_short_abort();
      t_long_abort();
      t_go_run();
      t_reserved();
      t_power_up(3'b000, 1'b0, TICK_DIV * (1 << (CNT_W + 2)), "R3");
      wait_for(0, 10, ok);
      chk("R3 load after master init", int'(ok), 1);
      chk_mode(3'b000, "R6 master serial");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule